// File: doc/BRIEF.md
# Watchdog Timer with Guarded Switch-Off

This block counts strobes from a slow oscillator. When no kick arrives before the count reaches a chosen limit, it raises a reset request. A 3-bit prescale code sets the limit. The base count is doubled once for each step of the code. The code changes while the timer runs only through a guarded path.

Software talks to the block through a 5-bit control register, with these fields:

- bit 4: window-open flag
- bit 3: enable
- bits 2..0: prescale code

Turning the timer on is a plain write. Turning it off, or retiming it while it runs, takes two writes:

1. An unlock write sets bits 4 and 3 together.
2. A follow-up write must land within a short window of clock cycles after the unlock write.

A safety-lock input removes the switch-off path entirely.

The control state machine has three states:

- `WD_OFF`: timer stopped, counter held at zero.
- `WD_RUN`: timer counting, register guarded.
- `WD_UNLOCKED`: timer counting, window open.

It has these transitions:

- **arm**: `WD_OFF` to `WD_RUN`, on a write with enable set.
- **arm-open**: `WD_OFF` to `WD_UNLOCKED`, on a write with enable and bit 4 set.
- **unlock**: `WD_RUN` to `WD_UNLOCKED`, on a write with bits 4 and 3 set.
- **reopen**: `WD_UNLOCKED` to `WD_UNLOCKED`, on another unlock write.
- **disarm**: `WD_UNLOCKED` to `WD_OFF`, on a write with enable clear while unlocked.
- **commit**: `WD_UNLOCKED` to `WD_RUN`, on any other write in the window.
- **expire**: `WD_UNLOCKED` to `WD_RUN`, when the window runs out without a write.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `rd_data` reads 0 and `wdt_reset` is low.
- R2: For prescale code k, `wdt_reset` pulses for exactly one clock cycle after BASE_TICKS·2^k oscillator ticks since the count last started. The count then restarts from zero.
- R3: The count advances only on cycles with `osc_tick` high. A `kick` while enabled returns the count to zero.
- R4: From the stopped state, a write with bit 3 set enables the timer without unlocking. The write also takes the prescale code from bits 2..0, and counting starts from zero.
- R5: While enabled, a write with bits 4 and 3 both set opens the window. An open window reads as bit 4 = 1.
- R6: A write with bit 3 clear disables the timer if it lands on clock edge 1 through WIN_CYCLES after the unlock write. Writing all zeros counts as such a write. Afterwards `rd_data` reads the written prescale with bits 4 and 3 low, and no further pulses occur.
- R7: A write with bit 3 clear outside the window is ignored: the enable bit stays 1 and the count keeps running.
- R8: Without a write, the window closes by itself after WIN_CYCLES clock cycles, and bit 4 reads 0 again.
- R9: While enabled, a write outside the window leaves the prescale code unchanged. A write inside the window loads it.
- R10: While `safety_lock` is high, no write disables the timer, even one inside the window.
- R11: A write with bit 4 set but bit 3 clear does not open the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator cycle, synchronous to clk |
| kick | input | 1 | Restarts the count |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Write value: bit 4 window request, bit 3 enable, bits 2..0 prescale |
| safety_lock | input | 1 | High forbids switching the timer off |
| rd_data | output | 5 | Register readback: bit 4 window open, bit 3 enable, bits 2..0 prescale |
| wdt_reset | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions assume that `osc_tick` is already a single-cycle strobe in the clock domain, and that BASE_TICKS is at least 2, so that two timeouts can never fall on adjacent cycles. They also assume that `wr_en` and `kick` are sampled as plain levels, one action per high cycle. The stimulus drives every input on the falling edge and raises each write strobe for exactly one cycle. It holds `osc_tick` high only in stretches where a bench-side count model tracks the ticks. It lowers `safety_lock` before every disable attempt meant to succeed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_OFF      = 2'd0,
        WD_RUN      = 2'd1,
        WD_UNLOCKED = 2'd2
    } wd_state_e;

    localparam int SEL_W   = 3;
    localparam int CTRL_W  = SEL_W + 2;
    localparam int EN_BIT  = SEL_W;
    localparam int CHG_BIT = SEL_W + 1;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              safety_lock,
    output logic              enabled,
    output logic              window_open,
    output logic [SEL_W-1:0]  sel
);
    localparam int WIN_W = $clog2(WIN_CYCLES + 1);

    wd_state_e              state_q, state_n;
    logic [WIN_W-1:0]       win_q, win_n;
    logic [SEL_W-1:0]       sel_q, sel_n;
    logic                   w_en, w_chg;
    logic [SEL_W-1:0]       w_sel;

    assign w_en  = wr_data[EN_BIT];
    assign w_chg = wr_data[CHG_BIT];
    assign w_sel = wr_data[SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            win_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_n;
            win_q   <= win_n;
            sel_q   <= sel_n;
        end
    end

    always_comb begin
        state_n = state_q;
        win_n   = win_q;
        sel_n   = sel_q;
        unique case (state_q)
            WD_OFF: begin
                if (wr_en) begin
                    sel_n = w_sel;
                    if (w_en) begin
                        state_n = w_chg ? WD_UNLOCKED : WD_RUN;
                        win_n   = WIN_W'(WIN_CYCLES);
                    end
                end
            end
            WD_RUN: begin
                if (wr_en && w_chg && w_en) begin
                    state_n = WD_UNLOCKED;
                    win_n   = WIN_W'(WIN_CYCLES);
                end
            end
            WD_UNLOCKED: begin
                if (wr_en) begin
                    sel_n = w_sel;
                    if (!w_en && !safety_lock) begin
                        state_n = WD_OFF;
                    end else if (w_chg && w_en) begin
                        state_n = WD_UNLOCKED;
                        win_n   = WIN_W'(WIN_CYCLES);
                    end else begin
                        state_n = WD_RUN;
                    end
                end else if (win_q <= WIN_W'(1)) begin
                    state_n = WD_RUN;
                end else begin
                    win_n = win_q - WIN_W'(1);
                end
            end
            default: state_n = WD_OFF;
        endcase
    end

    always_comb begin
        enabled     = (state_q != WD_OFF);
        window_open = (state_q == WD_UNLOCKED);
        sel         = sel_q;
    end

    // R6 R7
    disarm_only_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enabled) |-> $past(state_q == WD_UNLOCKED));

    // R10
    lock_holds_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (safety_lock && enabled) |=> enabled);

    // R8
    window_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_UNLOCKED && !wr_en && win_q == WIN_W'(1)) |=> state_q == WD_RUN);

    // R9
    sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN) |=> $stable(sel_q));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 16384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enabled,
    input  logic             osc_tick,
    input  logic             kick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int CNT_W     = $clog2(BASE_TICKS) + MAX_SHIFT + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_m1;

    assign limit_m1 = (CNT_W'(BASE_TICKS) << sel) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (!enabled || kick) begin
                cnt_q <= '0;
            end else if (osc_tick) begin
                if (cnt_q >= limit_m1) begin
                    cnt_q  <= '0;
                    expire <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R3
    kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && kick) |=> cnt_q == '0);

    // R3
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !osc_tick && !kick) |=> $stable(cnt_q));

    // R4
    start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled) |-> cnt_q == '0);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 16384,
    parameter int WIN_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick,
    input  logic        kick,
    input  logic        wr_en,
    input  logic [4:0]  wr_data,
    input  logic        safety_lock,
    output logic [4:0]  rd_data,
    output logic        wdt_reset
);
    logic             enabled;
    logic             window_open;
    logic [SEL_W-1:0] sel;

    wdog_ctrl #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .safety_lock (safety_lock),
        .enabled     (enabled),
        .window_open (window_open),
        .sel         (sel)
    );

    wdog_count #(.BASE_TICKS(BASE_TICKS)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .enabled  (enabled),
        .osc_tick (osc_tick),
        .kick     (kick),
        .sel      (sel),
        .expire   (wdt_reset)
    );

    assign rd_data = {window_open, enabled, sel};

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 5'd0 && !wdt_reset));
endmodule

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
    localparam int BASE = 4;
    localparam int WIN  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       kick = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = 5'd0;
    logic       safety_lock = 1'b0;
    logic [4:0] rd_data;
    logic       wdt_reset;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int exp_q[$];
    int mcnt = 0;
    int mlimit = BASE;
    bit men = 1'b0;

    wdog_guard #(.BASE_TICKS(BASE), .WIN_CYCLES(WIN)) u_wdog_guard (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .kick(kick),
        .wr_en(wr_en), .wr_data(wr_data), .safety_lock(safety_lock),
        .rd_data(rd_data), .wdt_reset(wdt_reset)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // monitor: pops the expected timeout cycle for every observed pulse
    always @(negedge clk) begin
        if (rst_n && wdt_reset) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2: actual pulse at cycle %0d expected none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    fails++;
                    $display("FAIL R2: actual pulse at cycle %0d expected %0d", cyc, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write(input logic [4:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 5'd0;
    endtask

    // driver: ticks and pushes expected pulse cycles from the model
    task automatic run_ticks(input int n);
        osc_tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (men) begin
                mcnt++;
                if (mcnt >= mlimit) begin
                    exp_q.push_back(cyc);
                    mcnt = 0;
                end
            end
        end
        osc_tick = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        mcnt = 0;
    endtask

    initial begin
        idle(3);
        // R1
        check("R1 rd_data", rd_data, 0);
        check("R1 wdt_reset", wdt_reset, 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 after release", rd_data, 0);

        // R4: enable from off with code 0
        write(5'b01000);
        men = 1'b1; mcnt = 0; mlimit = BASE;
        check("R4 enable readback", rd_data, 5'b01000);
        // R2: two timeouts at code 0
        run_ticks(9);
        idle(2);

        // R5: unlock, then R9 in-window prescale load to code 2
        write(5'b11000);
        check("R5 window flag", rd_data, 5'b11000);
        write(5'b01010);
        mlimit = BASE << 2;
        check("R9 in-window prescale", rd_data, 5'b01010);
        run_ticks(17);

        // R3: kick mid-count, no ticks means no progress
        run_ticks(10);
        do_kick();
        idle(40);
        run_ticks(20);

        // R7: clearing outside window ignored
        write(5'b00000);
        check("R7 enable kept", rd_data, 5'b01010);
        run_ticks(18);
        // R9: prescale write outside window ignored
        write(5'b01001);
        check("R9 outside prescale", rd_data, 5'b01010);
        // R11: change bit without enable opens nothing
        write(5'b10000);
        check("R11 no window", rd_data, 5'b01010);

        // R8: window self-closes
        write(5'b11010);
        idle(WIN - 1);
        check("R8 still open", rd_data, 5'b11010);
        idle(1);
        check("R8 closed", rd_data, 5'b01010);
        write(5'b00000);
        check("R8 late clear ignored", rd_data, 5'b01010);

        // R6: clear on the last window edge disables
        write(5'b11010);
        idle(WIN - 1);
        write(5'b00000);
        men = 1'b0;
        check("R6 disabled", rd_data, 5'b00000);
        run_ticks(40);

        // R4: enable with code 1
        write(5'b01001);
        men = 1'b1; mcnt = 0; mlimit = BASE << 1;
        check("R4 code1 readback", rd_data, 5'b01001);
        run_ticks(9);

        // R10: safety lock blocks switch-off
        safety_lock = 1'b1;
        write(5'b11001);
        write(5'b00000);
        mlimit = BASE;
        check("R10 still enabled", rd_data, 5'b01000);
        safety_lock = 1'b0;
        run_ticks(5);

        // R6: immediate clear in window with prescale
        write(5'b11000);
        write(5'b00011);
        men = 1'b0;
        check("R6 clear keeps prescale", rd_data, 5'b00011);
        run_ticks(10);
        idle(4);
        check("R2 all pulses seen", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule